// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Divider with Timed Unlock

This block divides a fast source clock by 1, 2, 4 and so on up to 256. Its output is a single-cycle clock-enable pulse, one per divided period. The CPU and every synchronous peripheral domain qualify their logic with this one enable, so they all change rate together. The divider counter runs on the undivided source clock.

Software can change the ratio only through a two-step timed unlock. A first write sets the change-enable bit and clears every other bit. A second write must follow within four source cycles; it clears the change-enable bit and carries the new divide selection. A second write that arrives late is ignored. An accepted setting does not take effect at once. It waits for the period in progress to finish at the old ratio, and the new ratio starts at that boundary. As a result, no enable interval is ever shorter than both the old and the new period, and no runt pulse appears. The setting is held in a one-deep pending slot until that boundary.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, `div_sel` reads 0 (divide by 1), `chg_en` reads 0, and `clk_en` is high in every cycle.
- R2: A write of exactly 8'h80 opens the change window. Bit 7 of `wr_data` is the change-enable bit and bits 3:0 are the divide selection. `chg_en` reads 1 in the cycle after that write. `chg_en` only rises after such a write.
- R3: A write with bit 7 = 0 is accepted if it is sampled on the 1st, 2nd, 3rd or 4th clock edge after the unlock edge. It loads bits 3:0 as the new selection.
- R4: `chg_en` drops by itself four edges after the unlock write. A write sampled on the 5th edge or later leaves the ratio unchanged.
- R5: Selection values 9 to 15 are reserved. A write carrying one of them inside the window closes the window and leaves the ratio unchanged. `div_sel` never exceeds 8.
- R6: With selection `s` in force, `clk_en` is a one-cycle pulse and consecutive pulses are exactly 2^s cycles apart.
- R7: A new ratio is adopted only at a pulse boundary. The interval in progress when a write is accepted completes at the old ratio, and every later interval uses the new one. No interval is shorter than both.
- R8: A write with bit 7 = 0 while the window is closed has no effect on the ratio or on `chg_en`.
- R9: A write with bit 7 = 1 and any other bit set is not an unlock. It neither opens the window nor restarts it.
- R10: `chg_en` returns to 0 in the cycle after a window write with bit 7 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 change-enable, bits 3:0 divide selection |
| clk_en | output | 1 | Divided clock-enable pulse shared by all domains |
| div_sel | output | 4 | Selection currently in force |
| chg_en | output | 1 | Change window open |

## Verification
The divider is driven through directed and random sequences, and every pulse interval is checked against the expected ratio.

The window is probed at three delays. A delay of 1 edge and a delay of 4 edges are both accepted; the 4-edge case finds an off-by-one at the closing end. A delay of 5 edges is ignored, which shows the window does expire.

Reserved codes, plain writes with no unlock, and near-miss unlock values such as 8'h81 show that only the exact unlock pattern opens the window. Slow-to-fast and fast-to-slow changes check that the interval in flight completes at the old length. Rewrites before adoption check that the last accepted value wins.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W = 4;

  // terminal count for a divide-by-2^s period
  function automatic int sel_limit(input logic [SEL_W-1:0] s);
    return (1 << int'(s)) - 1;
  endfunction

  function automatic logic sel_legal(input logic [SEL_W-1:0] s, input int max_sel);
    return int'(s) <= max_sel;
  endfunction
endpackage

// File: rtl/clkdiv_unlock.sv
module clkdiv_unlock
  import clkdiv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CE_BIT  = 7,
  parameter int WIN_CYC = 4,
  parameter int MAX_SEL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              chg_en,
  output logic              unlock_hit,
  output logic              load,
  output logic [SEL_W-1:0]  load_sel
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [DATA_W-1:0] UNLOCK_CODE = DATA_W'(1) << CE_BIT;

  logic [CW-1:0] win_cnt;
  logic          second_wr;

  assign unlock_hit = wr_en && (wr_data == UNLOCK_CODE);
  assign chg_en     = (win_cnt != '0);
  assign second_wr  = wr_en && !wr_data[CE_BIT] && chg_en;
  assign load_sel   = wr_data[SEL_W-1:0];
  assign load       = second_wr && sel_legal(load_sel, MAX_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n)          win_cnt <= '0;
    else if (unlock_hit) win_cnt <= CW'(WIN_CYC);
    else if (second_wr)  win_cnt <= '0;
    else if (chg_en)     win_cnt <= win_cnt - 1'b1;
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DEF_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_sel,
  output logic             clk_en,
  output logic [SEL_W-1:0] cur_sel,
  output logic             adopt
);
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] pend_sel;
  logic             pend_vld;
  logic             term;

  assign term   = (cnt == CNT_W'(sel_limit(cur_sel)));
  assign clk_en = term;
  assign adopt  = term && pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (term) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // pending slot: newest accepted value wins, adopted at a period end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_sel  <= SEL_W'(DEF_SEL);
      pend_sel <= SEL_W'(DEF_SEL);
      pend_vld <= 1'b0;
    end else begin
      if (adopt) cur_sel <= pend_sel;
      if (load) begin
        pend_sel <= load_sel;
        pend_vld <= 1'b1;
      end else if (term) begin
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CE_BIT  = 7,
  parameter int WIN_CYC = 4,
  parameter int MAX_SEL = 8,
  parameter int DEF_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              clk_en,
  output logic [SEL_W-1:0]  div_sel,
  output logic              chg_en
);
  localparam int CNT_W = (MAX_SEL < 1) ? 1 : MAX_SEL;

  logic             unlock_hit;
  logic             load;
  logic [SEL_W-1:0] load_sel;
  logic             adopt;

  clkdiv_unlock #(
    .DATA_W (DATA_W),
    .CE_BIT (CE_BIT),
    .WIN_CYC(WIN_CYC),
    .MAX_SEL(MAX_SEL)
  ) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .chg_en    (chg_en),
    .unlock_hit(unlock_hit),
    .load      (load),
    .load_sel  (load_sel)
  );

  clkdiv_counter #(
    .CNT_W  (CNT_W),
    .DEF_SEL(DEF_SEL)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_sel(load_sel),
    .clk_en  (clk_en),
    .cur_sel (div_sel),
    .adopt   (adopt)
  );
endmodule

// File: rtl/clkdiv_ctrl_chk.sv
module clkdiv_ctrl_chk #(
  parameter int WIN_CYC = 4,
  parameter int MAX_SEL = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_ce,
  input logic       clk_en,
  input logic [3:0] div_sel,
  input logic       chg_en,
  input logic       unlock_hit
);
  localparam int OW = $clog2(WIN_CYC + 2) + 1;
  logic [OW-1:0] open_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   open_age <= '0;
    else if (unlock_hit)                          open_age <= '0;
    else if (chg_en && open_age != {OW{1'b1}})    open_age <= open_age + 1'b1;
  end

  assert_unlock_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> chg_en);
  assert_open_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_en) |-> $past(unlock_hit));
  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> (int'(open_age) < WIN_CYC));
  assert_close_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && wr_en && !wr_ce && !unlock_hit) |=> !chg_en);
  assert_sel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(div_sel) <= MAX_SEL);
  assert_sel_moves_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(clk_en));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && div_sel != 4'd0) |=> (!clk_en || div_sel == 4'd0));
endmodule

bind clkdiv_ctrl clkdiv_ctrl_chk #(
  .WIN_CYC(WIN_CYC),
  .MAX_SEL(MAX_SEL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_ce     (wr_data[CE_BIT]),
  .clk_en    (clk_en),
  .div_sel   (div_sel),
  .chg_en    (chg_en),
  .unlock_hit(unlock_hit)
);

// File: tb/clkdiv_ctrl_bench.sv
`timescale 1ns/1ps
module clkdiv_ctrl_bench;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  wire        clk_en;
  wire  [3:0] div_sel;
  wire        chg_en;

  always #5 clk = ~clk;

  clkdiv_ctrl u_clkdiv_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .clk_en (clk_en),
    .div_sel(div_sel),
    .chg_en (chg_en)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit m_open = 0, m_pend = 0, have_last = 0;
  int m_unlock = 0, m_next = 0, gap_sel = 0, last_pulse = 0;

  function automatic int ratio_of(int s);
    return 1 << s;
  endfunction

  function automatic bit legal_sel(int s);
    return s <= 8;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse monitor: interval length and selection in force (R6, R7)
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && clk_en) begin
      if (have_last)
        check((cyc - last_pulse) == ratio_of(gap_sel), "R6 R7 interval",
              cyc - last_pulse, ratio_of(gap_sel));
      check(int'(div_sel) == gap_sel, "R6 div_sel", div_sel, gap_sel);
      if (m_pend) begin
        gap_sel = m_next;
        m_pend  = 0;
      end
      last_pulse = cyc;
      have_last  = 1;
    end
  end

  task automatic after_edge(string req);
    if (m_open && (cyc - m_unlock) >= WIN) m_open = 0;
    check(chg_en == m_open, req, chg_en, m_open);
  endtask

  task automatic wr(logic [7:0] d, string req);
    int e;
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    e = cyc;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (d == 8'h80) begin
      m_open = 1; m_unlock = e;
    end else if (m_open && (e - m_unlock) <= WIN && !d[7]) begin
      m_open = 0;
      if (legal_sel(int'(d[3:0]))) begin
        m_pend = 1; m_next = int'(d[3:0]);
      end
    end
    after_edge(req);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      after_edge("R4 window expiry");
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #1;
    check(div_sel == 4'd0, "R1 reset div_sel", div_sel, 0);
    check(chg_en == 1'b0, "R1 reset chg_en", chg_en, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(clk_en == 1'b1, "R1 divide by one", clk_en, 1);
    idle(4);

    // R2 R3 R10: immediate second write
    wr(8'h80, "R2 unlock opens");
    wr(8'h03, "R10 close on write");
    idle(40);
    // R3: last legal edge of the window
    wr(8'h80, "R2 unlock opens");
    idle(3);
    wr(8'h01, "R3 fourth edge accepted");
    idle(20);
    // R4: fifth edge is too late
    wr(8'h80, "R2 unlock opens");
    idle(4);
    wr(8'h05, "R4 late write ignored");
    idle(20);
    // R5: reserved code
    wr(8'h80, "R2 unlock opens");
    wr(8'h0C, "R5 reserved closes");
    idle(20);
    // R8: plain write without unlock
    wr(8'h02, "R8 no unlock");
    idle(20);
    // R9: near-miss unlock
    wr(8'h81, "R9 not an unlock");
    wr(8'h04, "R9 follow-up ignored");
    idle(20);
    // R7: slow to fast, fast to slow, rewrite before adoption
    wr(8'h80, "R2 unlock opens");
    wr(8'h08, "R3 accept slowest");
    idle(600);
    wr(8'h80, "R2 unlock opens");
    wr(8'h00, "R7 slow to fast");
    idle(20);
    wr(8'h80, "R2 unlock opens");
    wr(8'h06, "R7 fast to slow");
    wr(8'h80, "R2 unlock opens");
    wr(8'h02, "R7 rewrite wins");
    idle(300);

    for (int i = 0; i < 80; i++) begin
      int kind;
      kind = int'($urandom % 6);
      case (kind)
        0, 1, 2: begin
          wr(8'h80, "R2 unlock opens");
          idle(int'($urandom % 6));
          wr({1'b0, 3'($urandom), 4'($urandom % 16)}, "R3 R4 window write");
        end
        3: wr(8'($urandom), "R8 R9 random write");
        4: wr(8'h80 | 8'($urandom % 4), "R9 unlock pattern");
        default: idle(int'($urandom % 300));
      endcase
    end
    idle(600);
    finish_run();
  end
endmodule